// File: doc/BRIEF.md
# Streaming Pixel Color Converter

This block converts a byte stream of pixels from one packed format into another. Incoming bytes are first gathered into a pixel with three 8-bit components, called high, middle and low. The pixel then passes through a byte permutation and an optional 3x4 affine matrix with saturation. Finally it is serialized into the selected output format. The input format, the output format, the matrix enable, the permutation and the coefficients are static inputs. Format-only conversions, such as 24-bit to RGB565 or RGB565 to 24-bit, leave the matrix switched off.

Both stream sides use a valid/ready handshake, one byte per transfer. A transfer happens on a rising clock edge where valid and ready are both high. The configuration must be set while the stream is idle and held until every pixel of the job has left the output. The input format code 7 routes input bytes straight to the output with no storage on the way.

Top module: `pix_csc_pipe`

## Requirements
- R1: After reset, `m_valid` is 0 and, with a non-bypass input code, `s_ready` is 1.
- R2: With `cfg_in_sel` = 7, every input byte appears on the output unchanged, in order, one output byte for each input byte.
- R3: With `cfg_in_sel` = 0 (RGB565), two bytes form one pixel, low byte first. The 16-bit word is split as R = bits 15:11, G = bits 10:5 and B = bits 4:0. Each field is widened to 8 bits by repeating its top bits below it (R5 becomes {R,R[4:2]}, G6 becomes {G,G[5:4]}). The result is high = R, middle = G, low = B.
- R4: With `cfg_in_sel` = 2 or 3, three bytes form one pixel, in the order high, middle, low.
- R5: With `cfg_in_sel` = 1 (YUV422), the four bytes Y0, U, Y1, V yield two pixels. The first is {Y0,U,V} and the second is {Y1,U,V}, given as high, middle, low.
- R6: Before the matrix, the unpacked bytes b2 = high, b1 = middle and b0 = low are reordered by `cfg_scr`. The codes give high/middle/low as follows: 0 gives b2,b1,b0; 1 gives b2,b0,b1; 2 gives b1,b0,b2; 3 gives b1,b2,b0; 4 gives b0,b2,b1; 5 gives b0,b1,b2. Codes 6 and 7 must not be used.
- R7: With `cfg_mat_en` = 1, output row r (0 = high, 1 = middle, 2 = low) is floor((a·h + b·m + c·l) / 256) + d, saturated to 0..255. The coefficients a, b and c are signed 11-bit values with 8 fractional bits, stored in `cfg_coef_abc[(3r+k)*11 +: 11]` with k = 0, 1, 2 for a, b, c. The offset d is a signed 10-bit value in `cfg_coef_d[r*10 +: 10]`.
- R8: With `cfg_mat_en` = 0, the permuted pixel goes to the output stage unchanged, whatever the coefficients hold.
- R9: With `cfg_out_sel` = 0, each pixel becomes the word {high[7:3], middle[7:2], low[7:3]}, sent as two bytes, low byte first.
- R10: With `cfg_out_sel` = 1, each pair of pixels becomes four bytes: even high, even middle, odd high, odd low.
- R11: With `cfg_out_sel` = 2, each pixel is sent as three bytes: high, middle, low.
- R12: Under any pattern of `m_ready`, no byte is lost or repeated. While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_in_sel | input | 3 | Input format: 0 = RGB565, 1 = YUV422, 2/3 = 24-bit, 7 = bypass |
| cfg_mat_en | input | 1 | Matrix enable |
| cfg_out_sel | input | 2 | Output format: 0 = RGB565, 1 = YUV422, 2 = 24-bit |
| cfg_scr | input | 3 | Byte permutation code |
| cfg_coef_abc | input | 9*CF_W | Multiplier coefficients, three per row |
| cfg_coef_d | input | 3*OFS_W | Offsets, one per row |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte accepted |
| s_data | input | 8 | Input byte |
| m_valid | output | 1 | Output byte valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 8 | Output byte |

## Verification
Several input patterns are applied, and each one tells a particular fault apart:
- A sweep of RGB565 words, including all-zero, all-one and single-field words, separates correct field splitting and bit repetition from shifted or truncated fields.
- 24-bit pixels packed to RGB565 expose faults in the truncation position and the byte order.
- Pixels whose three bytes are all different, run under all six permutation codes, distinguish every permutation from every other one.
- YUV422 groups sent to both YUV422 and 24-bit output check that the chroma bytes are shared between the two pixels and placed correctly.
- A matrix with negative, fractional and offset coefficients drives results below 0 and above 255, which separates the saturation and rounding behaviour from plain wrap-around.
- The same coefficients with the matrix disabled must give the identity.
- A random `m_ready` pattern exposes any dropped, repeated or unstable byte.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   localparam int CW = 8;

   typedef struct packed {
      logic [CW-1:0] h;
      logic [CW-1:0] m;
      logic [CW-1:0] l;
   } pix_t;

   localparam logic [2:0] IN_RGB565 = 3'd0;
   localparam logic [2:0] IN_YUV422 = 3'd1;
   localparam logic [2:0] IN_BYPASS = 3'd7;

   localparam logic [1:0] OUT_RGB565 = 2'd0;
   localparam logic [1:0] OUT_YUV422 = 2'd1;

   function automatic pix_t permute(input pix_t p, input logic [2:0] code);
      pix_t r;
      case (code)
         3'd1:    r = '{h: p.h, m: p.l, l: p.m};
         3'd2:    r = '{h: p.m, m: p.l, l: p.h};
         3'd3:    r = '{h: p.m, m: p.h, l: p.l};
         3'd4:    r = '{h: p.l, m: p.h, l: p.m};
         3'd5:    r = '{h: p.l, m: p.m, l: p.h};
         default: r = p;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pcs_unpack.sv
module pcs_unpack
   import pcs_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [2:0]    in_sel,
   input  logic          s_valid,
   output logic          s_ready,
   input  logic [CW-1:0] s_data,
   output logic          p_valid,
   input  logic          p_ready,
   output pix_t          p_pix
);

   logic [3:0][CW-1:0] byte_q;
   logic [1:0]         cnt_q;
   logic               full_q;
   logic               half_q;
   logic [1:0]         last_idx;
   logic               is_yuv;
   logic [15:0]        word;

   assign is_yuv   = (in_sel == IN_YUV422);
   assign last_idx = (in_sel == IN_RGB565) ? 2'd1 : (is_yuv ? 2'd3 : 2'd2);
   assign s_ready  = !full_q;
   assign p_valid  = full_q;
   assign word     = {byte_q[1], byte_q[0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_q <= '0;
         cnt_q  <= '0;
         full_q <= 1'b0;
         half_q <= 1'b0;
      end else begin
         if (s_valid && s_ready) begin
            byte_q[cnt_q] <= s_data;
            if (cnt_q == last_idx) begin
               cnt_q  <= '0;
               full_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q + 2'd1;
            end
         end
         if (p_valid && p_ready) begin
            if (is_yuv && !half_q) begin
               half_q <= 1'b1;
            end else begin
               half_q <= 1'b0;
               full_q <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      case (in_sel)
         IN_RGB565: begin
            p_pix.h = {word[15:11], word[15:13]};
            p_pix.m = {word[10:5],  word[10:9]};
            p_pix.l = {word[4:0],   word[4:2]};
         end
         IN_YUV422: begin
            p_pix.h = half_q ? byte_q[2] : byte_q[0];
            p_pix.m = byte_q[1];
            p_pix.l = byte_q[3];
         end
         default: begin
            p_pix.h = byte_q[0];
            p_pix.m = byte_q[1];
            p_pix.l = byte_q[2];
         end
      endcase
   end

endmodule

// File: rtl/pcs_matrix.sv
module pcs_matrix
   import pcs_pkg::*;
#(
   parameter int CF_W       = 11,
   parameter int CF_FRAC    = 8,
   parameter int OFS_W      = 10,
   parameter bit HAS_MATRIX = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mat_en,
   input  logic [2:0]         scr,
   input  logic [9*CF_W-1:0]  coef_abc,
   input  logic [3*OFS_W-1:0] coef_d,
   input  logic               i_valid,
   output logic               i_ready,
   input  pix_t               i_pix,
   output logic               o_valid,
   input  logic               o_ready,
   output pix_t               o_pix
);

   localparam int PW = CF_W + CW + 1;
   localparam int AW = PW + 2;

   pix_t               sp;
   pix_t               mres;
   logic [2:0][CW-1:0] row_out;
   logic               v_q;
   pix_t               pix_q;

   assign sp = permute(i_pix, scr);

   generate
      if (HAS_MATRIX) begin : g_mat
         logic [2:0][CW-1:0] comp;
         assign comp = {sp.h, sp.m, sp.l};
         for (genvar r = 0; r < 3; r++) begin : g_row
            logic signed [AW-1:0] term [3];
            logic signed [AW-1:0] sum;
            logic signed [AW-1:0] shifted;
            logic signed [AW-1:0] res;
            logic signed [OFS_W-1:0] d_s;
            for (genvar k = 0; k < 3; k++) begin : g_term
               logic signed [CF_W-1:0] c_s;
               logic signed [AW-1:0]   c_x;
               logic signed [AW-1:0]   v_x;
               assign c_s = coef_abc[(r*3+k)*CF_W +: CF_W];
               assign c_x = {{(AW-CF_W){c_s[CF_W-1]}}, c_s};
               assign v_x = {{(AW-CW){1'b0}}, comp[2-k]};
               assign term[k] = c_x * v_x;
            end
            assign d_s     = coef_d[r*OFS_W +: OFS_W];
            assign sum     = term[0] + term[1] + term[2];
            assign shifted = sum >>> CF_FRAC;
            assign res     = shifted + {{(AW-OFS_W){d_s[OFS_W-1]}}, d_s};
            assign row_out[2-r] = res[AW-1] ? '0 :
                                  (|res[AW-2:CW]) ? '1 : res[CW-1:0];
         end
         assign mres = {row_out[2], row_out[1], row_out[0]};
      end else begin : g_nomat
         assign row_out = '0;
         assign mres    = sp;
      end
   endgenerate

   assign i_ready = !v_q || o_ready;
   assign o_valid = v_q;
   assign o_pix   = pix_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         pix_q <= '0;
      end else if (i_ready) begin
         v_q <= i_valid;
         if (i_valid) pix_q <= mat_en ? mres : sp;
      end
   end

endmodule

// File: rtl/pcs_pack.sv
module pcs_pack
   import pcs_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    out_sel,
   input  logic          i_valid,
   output logic          i_ready,
   input  pix_t          i_pix,
   output logic          m_valid,
   input  logic          m_ready,
   output logic [CW-1:0] m_data,
   output logic [1:0]    idx_o
);

   logic [3:0][CW-1:0] byte_q;
   logic [1:0]         idx_q;
   logic               busy_q;
   logic               half_q;
   logic [1:0]         last_idx;
   logic [15:0]        w565;

   assign last_idx = (out_sel == OUT_RGB565) ? 2'd1 :
                     (out_sel == OUT_YUV422) ? 2'd3 : 2'd2;
   assign w565     = {i_pix.h[7:3], i_pix.m[7:2], i_pix.l[7:3]};
   assign i_ready  = !busy_q;
   assign m_valid  = busy_q;
   assign m_data   = byte_q[idx_q];
   assign idx_o    = idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_q <= '0;
         idx_q  <= '0;
         busy_q <= 1'b0;
         half_q <= 1'b0;
      end else begin
         if (i_valid && i_ready) begin
            case (out_sel)
               OUT_RGB565: begin
                  byte_q[0] <= w565[7:0];
                  byte_q[1] <= w565[15:8];
                  busy_q    <= 1'b1;
               end
               OUT_YUV422: begin
                  if (!half_q) begin
                     byte_q[0] <= i_pix.h;
                     byte_q[1] <= i_pix.m;
                     half_q    <= 1'b1;
                  end else begin
                     byte_q[2] <= i_pix.h;
                     byte_q[3] <= i_pix.l;
                     half_q    <= 1'b0;
                     busy_q    <= 1'b1;
                  end
               end
               default: begin
                  byte_q[0] <= i_pix.h;
                  byte_q[1] <= i_pix.m;
                  byte_q[2] <= i_pix.l;
                  busy_q    <= 1'b1;
               end
            endcase
         end
         if (m_valid && m_ready) begin
            if (idx_q == last_idx) begin
               idx_q  <= '0;
               busy_q <= 1'b0;
            end else begin
               idx_q <= idx_q + 2'd1;
            end
         end
      end
   end

endmodule

// File: rtl/pix_csc_pipe.sv
module pix_csc_pipe
   import pcs_pkg::*;
#(
   parameter int CF_W       = 11,
   parameter int CF_FRAC    = 8,
   parameter int OFS_W      = 10,
   parameter bit HAS_MATRIX = 1'b1
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         cfg_in_sel,
   input  logic               cfg_mat_en,
   input  logic [1:0]         cfg_out_sel,
   input  logic [2:0]         cfg_scr,
   input  logic [9*CF_W-1:0]  cfg_coef_abc,
   input  logic [3*OFS_W-1:0] cfg_coef_d,
   input  logic               s_valid,
   output logic               s_ready,
   input  logic [7:0]         s_data,
   output logic               m_valid,
   input  logic               m_ready,
   output logic [7:0]         m_data
);

   generate
      if (CF_FRAC >= CF_W) begin : g_bad_frac
         $error("CF_FRAC must be smaller than CF_W");
      end
      if (OFS_W < 2 || OFS_W > CF_W + CW) begin : g_bad_ofs
         $error("OFS_W out of range");
      end
   endgenerate

   logic       byp;
   logic       up_s_valid, up_s_ready;
   logic       up_valid, up_ready;
   pix_t       up_pix;
   logic       mt_valid, mt_ready;
   pix_t       mt_pix;
   logic       pk_valid, pk_ready;
   logic [7:0] pk_data;
   logic [1:0] pk_idx;

   assign byp        = (cfg_in_sel == IN_BYPASS);
   assign up_s_valid = s_valid && !byp;
   assign s_ready    = byp ? m_ready : up_s_ready;
   assign m_valid    = byp ? s_valid : pk_valid;
   assign m_data     = byp ? s_data  : pk_data;
   assign pk_ready   = m_ready && !byp;

   pcs_unpack u_unpack (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_sel  (cfg_in_sel),
      .s_valid (up_s_valid),
      .s_ready (up_s_ready),
      .s_data  (s_data),
      .p_valid (up_valid),
      .p_ready (up_ready),
      .p_pix   (up_pix)
   );

   pcs_matrix #(
      .CF_W       (CF_W),
      .CF_FRAC    (CF_FRAC),
      .OFS_W      (OFS_W),
      .HAS_MATRIX (HAS_MATRIX)
   ) u_matrix (
      .clk      (clk),
      .rst_n    (rst_n),
      .mat_en   (cfg_mat_en),
      .scr      (cfg_scr),
      .coef_abc (cfg_coef_abc),
      .coef_d   (cfg_coef_d),
      .i_valid  (up_valid),
      .i_ready  (up_ready),
      .i_pix    (up_pix),
      .o_valid  (mt_valid),
      .o_ready  (mt_ready),
      .o_pix    (mt_pix)
   );

   pcs_pack u_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .out_sel (cfg_out_sel),
      .i_valid (mt_valid),
      .i_ready (mt_ready),
      .i_pix   (mt_pix),
      .m_valid (pk_valid),
      .m_ready (pk_ready),
      .m_data  (pk_data),
      .idx_o   (pk_idx)
   );

endmodule

// File: rtl/pcs_csc_chk.sv
module pcs_csc_chk
   import pcs_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_out_sel,
   input logic       m_valid,
   input logic       m_ready,
   input logic [7:0] m_data,
   input logic       up_valid,
   input logic       up_ready,
   input pix_t       up_pix,
   input logic       mt_valid,
   input logic       mt_ready,
   input pix_t       mt_pix,
   input logic [1:0] pk_idx
);

   // R12
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready |=> m_valid && $stable(m_data));

   // R12
   unpack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid && !up_ready |=> up_valid && $stable(up_pix));

   // R12
   matrix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mt_valid && !mt_ready |=> mt_valid && $stable(mt_pix));

   // R9
   rgb565_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_out_sel == OUT_RGB565 |-> pk_idx <= 2'd1);

   // R11
   pix24_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_out_sel == 2'd2 |-> pk_idx <= 2'd2);

endmodule

bind pix_csc_pipe pcs_csc_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_out_sel (cfg_out_sel),
   .m_valid     (m_valid),
   .m_ready     (m_ready),
   .m_data      (m_data),
   .up_valid    (up_valid),
   .up_ready    (up_ready),
   .up_pix      (up_pix),
   .mt_valid    (mt_valid),
   .mt_ready    (mt_ready),
   .mt_pix      (mt_pix),
   .pk_idx      (pk_idx)
);

// File: tb/tb_pix_csc_pipe.sv
module tb_pix_csc_pipe;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cfg_in_sel = 3'd3;
   logic        cfg_mat_en = 1'b0;
   logic [1:0]  cfg_out_sel = 2'd2;
   logic [2:0]  cfg_scr = 3'd0;
   logic [98:0] cfg_coef_abc = '0;
   logic [29:0] cfg_coef_d = '0;
   logic        s_valid = 1'b0;
   logic        s_ready;
   logic [7:0]  s_data = '0;
   logic        m_valid;
   logic        m_ready = 1'b0;
   logic [7:0]  m_data;

   always #4 clk = ~clk;

   pix_csc_pipe dut (
      .clk(clk), .rst_n(rst_n), .cfg_in_sel(cfg_in_sel), .cfg_mat_en(cfg_mat_en),
      .cfg_out_sel(cfg_out_sel), .cfg_scr(cfg_scr), .cfg_coef_abc(cfg_coef_abc),
      .cfg_coef_d(cfg_coef_d), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
      .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
   );

   int nchk = 0;
   int nerr = 0;
   logic [7:0] in_b  [0:2047];
   logic [7:0] exp_b [0:2047];
   int n_in, n_exp;
   int rmode;
   bit out_half;
   logic [23:0] out_even;
   int ca [3][3];
   int cd [3];

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   task automatic clear_job();
      n_in = 0; n_exp = 0; out_half = 1'b0;
   endtask

   task automatic add_in(input logic [7:0] b);
      in_b[n_in] = b; n_in++;
   endtask

   task automatic add_exp(input logic [7:0] b);
      exp_b[n_exp] = b; n_exp++;
   endtask

   function automatic logic [23:0] scr_f(input logic [23:0] p, input int code);
      logic [7:0] b2, b1, b0;
      {b2, b1, b0} = p;
      case (code)
         1: return {b2, b0, b1};
         2: return {b1, b0, b2};
         3: return {b1, b2, b0};
         4: return {b0, b2, b1};
         5: return {b0, b1, b2};
         default: return p;
      endcase
   endfunction

   function automatic logic [23:0] mat_f(input logic [23:0] p);
      logic [23:0] r;
      int comp [3];
      comp[0] = int'(p[23:16]); comp[1] = int'(p[15:8]); comp[2] = int'(p[7:0]);
      for (int i = 0; i < 3; i++) begin
         int acc;
         acc = ca[i][0]*comp[0] + ca[i][1]*comp[1] + ca[i][2]*comp[2];
         acc = (acc >>> 8) + cd[i];
         if (acc < 0) acc = 0;
         if (acc > 255) acc = 255;
         r[23-8*i -: 8] = 8'(acc);
      end
      return r;
   endfunction

   task automatic emit_pix(input logic [23:0] p);
      logic [15:0] w;
      case (cfg_out_sel)
         2'd0: begin
            w = {p[23:19], p[15:10], p[7:3]};
            add_exp(w[7:0]); add_exp(w[15:8]);
         end
         2'd1: begin
            if (!out_half) begin
               out_even = p; out_half = 1'b1;
            end else begin
               add_exp(out_even[23:16]); add_exp(out_even[15:8]);
               add_exp(p[23:16]); add_exp(p[7:0]);
               out_half = 1'b0;
            end
         end
         default: begin
            add_exp(p[23:16]); add_exp(p[15:8]); add_exp(p[7:0]);
         end
      endcase
   endtask

   task automatic proc_pix(input logic [23:0] p);
      logic [23:0] q;
      q = scr_f(p, int'(cfg_scr));
      if (cfg_mat_en) q = mat_f(q);
      emit_pix(q);
   endtask

   task automatic set_coefs();
      for (int r = 0; r < 3; r++) begin
         for (int k = 0; k < 3; k++) cfg_coef_abc[(r*3+k)*11 +: 11] = 11'(ca[r][k]);
         cfg_coef_d[r*10 +: 10] = 10'(cd[r]);
      end
   endtask

   task automatic run(input string tag);
      int ii = 0;
      int got = 0;
      int cyc = 0;
      bit stall_prev = 1'b0;
      logic [7:0] d_prev = '0;
      while ((ii < n_in || got < n_exp) && cyc < 20000) begin
         @(negedge clk);
         m_ready = (rmode == 0) ? 1'b1 : (($urandom % 4) != 0);
         if (ii < n_in) begin s_valid = 1'b1; s_data = in_b[ii]; end
         else s_valid = 1'b0;
         #1;
         if (stall_prev)
            chk(m_valid && m_data == d_prev, {"R12 stall hold ", tag}, int'(m_data), int'(d_prev));
         stall_prev = m_valid && !m_ready;
         d_prev = m_data;
         if (m_valid && m_ready) begin
            if (got < n_exp)
               chk(m_data == exp_b[got], tag, int'(m_data), int'(exp_b[got]));
            got++;
         end
         if (s_valid && s_ready) ii++;
         cyc++;
      end
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         s_valid = 1'b0; m_ready = 1'b1;
         #1;
         if (m_valid) got++;
      end
      chk(got == n_exp, {"R12 byte count ", tag}, got, n_exp);
      m_ready = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [15:0] w;
      logic [23:0] p;
      repeat (3) @(negedge clk);
      #1;
      chk(m_valid == 1'b0, "R1 m_valid at reset", int'(m_valid), 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(m_valid == 1'b0, "R1 m_valid after reset", int'(m_valid), 0);
      chk(s_ready == 1'b1, "R1 s_ready after reset", int'(s_ready), 1);

      // R2 bypass, code 7
      cfg_in_sel = 3'd7; rmode = 1; clear_job();
      for (int i = 0; i < 40; i++) begin add_in(8'(i*37 + 5)); add_exp(8'(i*37 + 5)); end
      run("R2 bypass");

      // R3 with R11: RGB565 in, 24-bit out
      cfg_in_sel = 3'd0; cfg_out_sel = 2'd2; cfg_scr = 3'd0; cfg_mat_en = 1'b0;
      for (int pass = 0; pass < 2; pass++) begin
         rmode = pass; clear_job();
         for (int i = 0; i < 70; i++) begin
            if (i == 0) w = 16'h0000;
            else if (i == 1) w = 16'hFFFF;
            else if (i == 2) w = 16'hF800;
            else if (i == 3) w = 16'h07E0;
            else if (i == 4) w = 16'h001F;
            else w = 16'(i * 937 + pass * 4099);
            add_in(w[7:0]); add_in(w[15:8]);
            proc_pix({w[15:11], w[15:13], w[10:5], w[10:9], w[4:0], w[4:2]});
         end
         run("R3 R11 rgb565 to 24");
      end

      // R4 with R9: 24-bit in (codes 3 and 2), RGB565 out
      cfg_out_sel = 2'd0;
      for (int code = 2; code < 4; code++) begin
         cfg_in_sel = 3'(code); rmode = 1; clear_job();
         for (int i = 0; i < 60; i++) begin
            p = 24'(i * 104729 + code * 7777);
            add_in(p[23:16]); add_in(p[15:8]); add_in(p[7:0]);
            proc_pix(p);
         end
         run("R4 R9 24 to rgb565");
      end

      // R6 permutation sweep
      cfg_in_sel = 3'd2; cfg_out_sel = 2'd2;
      for (int code = 0; code < 6; code++) begin
         cfg_scr = 3'(code); rmode = code % 2; clear_job();
         for (int i = 0; i < 8; i++) begin
            p = {8'(8'h10 + i), 8'(8'h80 + i), 8'(8'hE0 + i)};
            add_in(p[23:16]); add_in(p[15:8]); add_in(p[7:0]);
            proc_pix(p);
         end
         run("R6 permute");
      end
      cfg_scr = 3'd0;

      // R5 with R10: YUV422 in, YUV422 out and 24-bit out
      cfg_in_sel = 3'd1;
      for (int oc = 1; oc < 3; oc++) begin
         cfg_out_sel = 2'(oc); rmode = 1; clear_job();
         for (int g = 0; g < 20; g++) begin
            logic [7:0] y0, u, y1, v;
            y0 = 8'(g * 13); u = 8'(g * 29 + 3); y1 = 8'(255 - g * 7); v = 8'(g * 51 + 9);
            add_in(y0); add_in(u); add_in(y1); add_in(v);
            proc_pix({y0, u, v}); proc_pix({y1, u, v});
         end
         run(oc == 1 ? "R5 R10 yuv422 to yuv422" : "R5 yuv422 to 24");
      end

      // R7 matrix with clamping
      ca[0] = '{256, 0, 0};    cd[0] = 0;
      ca[1] = '{-256, 512, 128}; cd[1] = -20;
      ca[2] = '{64, 64, 128};  cd[2] = 100;
      set_coefs();
      cfg_in_sel = 3'd3; cfg_out_sel = 2'd2; cfg_mat_en = 1'b1;
      for (int pass = 0; pass < 2; pass++) begin
         rmode = pass; clear_job();
         for (int i = 0; i < 64; i++) begin
            p = {8'(i * 4), 8'(i * 97 + pass * 31), 8'(255 - i * 3)};
            add_in(p[23:16]); add_in(p[15:8]); add_in(p[7:0]);
            proc_pix(p);
         end
         run("R7 matrix");
      end

      // R7 fractional rounding toward minus infinity
      ca[0] = '{-1, 0, 0}; cd[0] = 5;
      ca[1] = '{3, -2, 1}; cd[1] = 0;
      ca[2] = '{0, 0, 383}; cd[2] = -200;
      set_coefs(); rmode = 1; clear_job();
      for (int i = 0; i < 32; i++) begin
         p = {8'(i * 8 + 1), 8'(i * 5), 8'(i * 8 + 7)};
         add_in(p[23:16]); add_in(p[15:8]); add_in(p[7:0]);
         proc_pix(p);
      end
      run("R7 matrix fraction");

      // R8 matrix disabled with nonzero coefficients
      cfg_mat_en = 1'b0; rmode = 1; clear_job();
      for (int i = 0; i < 16; i++) begin
         p = 24'(i * 65537 + 12345);
         add_in(p[23:16]); add_in(p[15:8]); add_in(p[7:0]);
         add_exp(p[23:16]); add_exp(p[15:8]); add_exp(p[7:0]);
      end
      run("R8 matrix off");

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule